// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus when a slave device holds SDA low because a transfer was cut off in the middle of a byte. Higher-level control triggers it once a wait for the bus to go idle has timed out. While it runs, it owns the SCL and SDA drive levels. It first leaves both lines released. It then clocks nine SCL pulses, which lets the slave shift out the rest of its byte and let go of SDA. Finally it forms a stop condition: SDA is pulled low while SCL is high, then released. After that the pins go back to the normal functional path.

Every step of the sequence lasts one half-period of the recovery clock. The half-period is set by an external tick: the sequencer moves to its next step only in a cycle where the tick is high. Changing the tick rate changes the recovery speed. The busy flag tells the pin multiplexer outside the block which source owns the pins. The done pulse tells the controller that the sequence has finished.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset, scl_o and sda_o are 1 (released), busy_o is 0 and done_o is 0.
- R2: A start_i sampled high while idle makes busy_o 1 from the next cycle. The first step leaves scl_o=1 and sda_o=1.
- R3: The sequence then gives exactly NUM_PULSES (default 9) SCL pulses. Each pulse is one step with scl_o=0 followed by one step with scl_o=1. sda_o stays 1 during all pulses.
- R4: After the last pulse, one step drives sda_o=0 with scl_o=1. A final step then releases sda_o while scl_o stays 1, which forms a stop condition.
- R5: The sequencer leaves a step only at a clock edge where tick_i is high. Every step after the first therefore lasts exactly one tick interval.
- R6: busy_o stays 1 until the final release step ends. done_o is then high for exactly one cycle, which is the first cycle with busy_o at 0.
- R7: A start_i that arrives while busy_o is 1 is ignored. The sequence keeps its shape, gives exactly one done pulse, and does not restart.
- R8: Whenever busy_o is 0, scl_o and sda_o are both 1, so the normal path has the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery trigger, sampled while idle |
| tick_i | input | 1 | Half-period tick; the step advances when high |
| scl_o | output | 1 | SCL drive level (1 = released) |
| sda_o | output | 1 | SDA drive level (1 = released) |
| busy_o | output | 1 | Sequencer owns the pins |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The sequence is run three times: with tick_i held high all the time, with a tick every fifth cycle, and with a tick every third cycle plus a second trigger arriving mid-run. The first two runs separate a correct step order from one that only works at a single step length. Each line-level change is compared against the expected order: entry, nine low/high pulses, SDA low with SCL high, then release. Every step length is measured against the tick interval, which exposes extra or missing pulses and steps that skip the tick. The mid-run trigger run checks that the sequence neither lengthens nor restarts and that exactly one done pulse appears.

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic scl_o,
  output logic sda_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(NUM_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(NUM_PULSES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTRY, ST_LOW, ST_HIGH, ST_STOP_LO, ST_STOP_REL
  } step_t;

  step_t            state;
  logic [CNT_W-1:0] pulse_cnt;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pulse_cnt <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state     <= ST_ENTRY;
          pulse_cnt <= '0;
        end
        ST_ENTRY: if (tick_i) state <= ST_LOW;
        ST_LOW:   if (tick_i) state <= ST_HIGH;
        ST_HIGH:  if (tick_i) begin
          if (pulse_cnt == LAST_PULSE) state <= ST_STOP_LO;
          else begin
            state     <= ST_LOW;
            pulse_cnt <= pulse_cnt + 1'b1;
          end
        end
        ST_STOP_LO:  if (tick_i) state <= ST_STOP_REL;
        ST_STOP_REL: if (tick_i) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scl_o  = (state != ST_LOW);
  assign sda_o  = (state != ST_STOP_LO);
  assign busy_o = (state != ST_IDLE);
  assign done_o = done_q;

  logic             scl_q;
  logic [CNT_W:0]   rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      rise_cnt <= '0;
    end else begin
      scl_q <= scl_o;
      if (state == ST_IDLE && !done_q) rise_cnt <= '0;
      else if (busy_o && scl_o && !scl_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o)); // R8
  AST_SDA_QUIET_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_o |-> sda_o); // R3
  AST_STOP_EDGES_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_o) || $rose(sda_o)) |-> scl_o); // R4
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> ($stable(scl_o) && $stable(sda_o) && busy_o)); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rise_cnt == (CNT_W+1)'(NUM_PULSES))); // R3
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && scl_o && sda_o)); // R2
endmodule

// File: tb/i2c_bus_unjam_tb_top.sv
module i2c_bus_unjam_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic scl_o, sda_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int tick_period = 1;
  int done_seen = 0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_unjam #(.NUM_PULSES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .scl_o(scl_o), .sda_o(sda_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1 >= tick_period) ? 0 : cnt + 1;
      tick_i = (cnt == 0);
    end
  end

  initial begin
    logic [1:0] prev_val = 2'b11;
    logic prev_busy = 1'b0;
    int run = 0;
    int idx = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy_o && (!prev_busy || {scl_o, sda_o} != prev_val)) begin
          if (!prev_busy) begin
            idx = 0;
            check({scl_o, sda_o} == 2'b11, "R2 entry levels", {scl_o, sda_o}, 3);
          end else if (idx >= 2) begin
            check(run == tick_period, "R5 step length", run, tick_period);
          end
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected level change", {scl_o, sda_o}, 0);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            check({scl_o, sda_o} == e, (idx == 19) ? "R4 stop sda low" :
                  (idx == 20) ? "R4 stop release" : "R3 pulse levels", {scl_o, sda_o}, e);
          end
          idx++;
          run = 1;
        end else if (busy_o) begin
          run++;
        end
        if (!busy_o && prev_busy) begin
          check(run == tick_period, "R5 final step length", run, tick_period);
          check(done_o == 1'b1, "R6 done with busy fall", done_o, 1);
        end
        if (done_o) begin
          done_seen++;
          check(!busy_o && prev_busy, "R6 done only after busy", busy_o, 0);
        end
        if (!busy_o)
          check(scl_o && sda_o, "R8 released when idle", {scl_o, sda_o}, 3);
        prev_busy = busy_o;
        prev_val = {scl_o, sda_o};
      end
    end
  end

  task automatic run_seq(input int period, input bit inject);
    tick_period = period;
    done_seen = 0;
    exp_q.push_back(2'b11);
    for (int i = 0; i < NP; i++) begin
      exp_q.push_back(2'b01);
      exp_q.push_back(2'b11);
    end
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b11);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    if (inject) begin
      repeat (7) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R3 all steps seen", exp_q.size(), 0);
    check(done_seen == 1, inject ? "R7 single done" : "R6 single done", done_seen, 1);
    check(busy_o == 1'b0, inject ? "R7 no restart" : "R6 stays idle", busy_o, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
    check(sda_o == 1'b1, "R1 reset sda", sda_o, 1);
    check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_seq(1, 1'b0);
    run_seq(5, 1'b0);
    run_seq(3, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule